// File: doc/BRIEF.md
# Blocking Rendezvous Channel Interconnect

This block joins a small group of processor cores through fixed point-to-point channels. Each core has four link slots. A core starts a transfer by presenting a request that carries an operation code, a slot index and, for a send, one data word. A receive uses code 0x4 and a send uses code 0x5. The slot index stands in for the channel name. A parameter table built at elaboration connects each (core, slot) endpoint to one peer endpoint, or leaves it unconnected.

No buffering is involved. A core that arrives first waits, holding its request, until the core on the other end of the wire arrives with the opposite direction. The block then copies exactly one word from the sender to the receiver and acknowledges both cores with a one-cycle pulse in the same cycle. The core keeps its program counter frozen while it waits and steps past the channel operation when the acknowledge comes. Once the acknowledge has been given, no waiting state remains in the block.

The block also reports two faults. A request that names a bad slot, an unconnected slot or an unknown operation is flagged together with the offending core and its program counter. A network in which every core waits and no pair can complete is flagged as deadlocked, and the slot each core waits on is reported.

Top module: `link_rendezvous`

## Requirements
- R1: After reset, ackOut, errValid, deadlock, waitSlot and rxData are all zero.
- R2: An op of 0x4 is a receive and 0x5 is a send. The low two bits of the slot select the endpoint. Each 8-bit map entry holds a wired flag in bit 7 and the peer endpoint (peer core times 4 plus peer slot) in bits 5:0.
- R3: A sender that arrives before its receiver gets no acknowledge while it waits alone.
- R4: A receiver that arrives before its sender gets no acknowledge while it waits alone.
- R5: Once both wired ends request in opposite directions, both acknowledge bits go high together in the next cycle. In that same cycle the receiver's rxData holds the sender's word, and it keeps that word until the receiver's next transfer.
- R6: Each acknowledge lasts exactly one cycle, even when the requests are still present in the acknowledge cycle.
- R7: If both ends of a wire request send, or both request receive, neither end is acknowledged.
- R8: A request with a slot of 4 or more, an unconnected slot, or an op other than 0x4 or 0x5 is never acknowledged. In the next cycle it raises errValid, with errCore set to the lowest such core index and errPc set to that core's program counter.
- R9: When every core holds a well-formed request and no pair can complete, deadlock goes high in the next cycle. waitSlot then carries each core's slot in two bits, core 0 in the lowest bits.
- R10: Deadlock stays low while any core is idle or holds an erroneous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_CORES | Per-core request present, held until acknowledged |
| reqOp | input | NUM_CORES*4 | Per-core operation code (0x4 receive, 0x5 send) |
| reqSlot | input | NUM_CORES*SLOT_IN_W | Per-core slot index from the B register |
| reqData | input | NUM_CORES*DATA_W | Per-core word to send from the A register |
| reqPc | input | NUM_CORES*PC_W | Per-core program counter, used for error reporting |
| ackOut | output | NUM_CORES | Per-core one-cycle completion pulse |
| rxData | output | NUM_CORES*DATA_W | Per-core received word |
| errValid | output | 1 | A bad request was present in the previous cycle |
| errCore | output | CORE_W | Lowest index of a core with a bad request |
| errPc | output | PC_W | Program counter of that core |
| deadlock | output | 1 | All cores are stuck waiting |
| waitSlot | output | NUM_CORES*2 | Slot each core waits on, valid with deadlock |

## Verification
The bench presents transfers on every wired pair with random data, random direction and random gaps of up to four cycles between arrivals. Sometimes the sender is first and sometimes the receiver. A design that acknowledged a lone requester early, or that latched the word from the wrong core, would fail these transfers. Requests are kept present for one cycle after the acknowledge, which exposes a design that acknowledges the same rendezvous twice. Same-direction pairs, unconnected and out-of-range slots, unknown ops, several bad requests at once, and full and partial stalls complete the set. They catch a design that pairs two senders, reports the wrong core or program counter, or raises deadlock while a core is still idle.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam int LINK_SLOTS  = 4;
  localparam int LINK_SLOT_W = 2;
  localparam int OP_W        = 4;
  localparam int ENTRY_W     = 8;
  localparam logic [OP_W-1:0] OP_RECV = 4'h4;
  localparam logic [OP_W-1:0] OP_SEND = 4'h5;

  // Strobes from control to datapath.
  typedef struct packed {
    logic errHit;
    logic deadHit;
  } link_strobe_t;

  // Default wiring for four cores: entry e = core*4 + slot,
  // bit 7 = wired, bits 5:0 = peer endpoint.
  function automatic logic [4*LINK_SLOTS*ENTRY_W-1:0] link_default_map();
    logic [4*LINK_SLOTS*ENTRY_W-1:0] m;
    m = '0;
    m[0*ENTRY_W  +: ENTRY_W] = 8'h84;  // c0s0 <-> c1s0
    m[4*ENTRY_W  +: ENTRY_W] = 8'h80;
    m[9*ENTRY_W  +: ENTRY_W] = 8'h8E;  // c2s1 <-> c3s2
    m[14*ENTRY_W +: ENTRY_W] = 8'h89;
    m[2*ENTRY_W  +: ENTRY_W] = 8'h8B;  // c0s2 <-> c2s3
    m[11*ENTRY_W +: ENTRY_W] = 8'h82;
    m[7*ENTRY_W  +: ENTRY_W] = 8'h8C;  // c1s3 <-> c3s0
    m[12*ENTRY_W +: ENTRY_W] = 8'h87;
    return m;
  endfunction
endpackage

// File: rtl/link_ctrl.sv
module link_ctrl
  import link_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SLOT_IN_W = 8,
  parameter int CORE_W    = 2,
  parameter logic [NUM_CORES*LINK_SLOTS*ENTRY_W-1:0] PEER_MAP = '0
) (
  input  logic [NUM_CORES-1:0]             reqValid,
  input  logic [NUM_CORES*OP_W-1:0]        reqOp,
  input  logic [NUM_CORES*SLOT_IN_W-1:0]   reqSlot,
  input  logic [NUM_CORES-1:0]             ackQ,
  output logic [NUM_CORES-1:0]             matchNext,
  output logic [NUM_CORES-1:0]             loadRx,
  output logic [NUM_CORES*CORE_W-1:0]      srcCore,
  output logic [NUM_CORES*LINK_SLOT_W-1:0] slotLow,
  output logic [CORE_W-1:0]                errCoreNext,
  output link_strobe_t                     strobe
);
  logic [NUM_CORES-1:0] good, bad, isSend, isRecv;
  logic [CORE_W-1:0]      peerCore [NUM_CORES];
  logic [LINK_SLOT_W-1:0] peerSlot [NUM_CORES];
  logic [LINK_SLOT_W-1:0] ownSlot  [NUM_CORES];

  // Decode each core's request against the wiring table.
  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      logic [SLOT_IN_W-1:0] slotC;
      logic [5:0]           peer;
      logic                 wired, inRange, peerOk, elig;
      int                   ep;
      slotC       = reqSlot[c*SLOT_IN_W +: SLOT_IN_W];
      ownSlot[c]  = slotC[LINK_SLOT_W-1:0];
      inRange     = slotC < SLOT_IN_W'(LINK_SLOTS);
      ep          = c*LINK_SLOTS + int'(slotC[LINK_SLOT_W-1:0]);
      wired       = PEER_MAP[ep*ENTRY_W + 7];
      peer        = PEER_MAP[ep*ENTRY_W +: 6];
      peerOk      = {1'b0, peer[5:2]} < 5'(NUM_CORES);
      peerCore[c] = peer[2 +: CORE_W];
      peerSlot[c] = peer[1:0];
      isSend[c]   = reqOp[c*OP_W +: OP_W] == OP_SEND;
      isRecv[c]   = reqOp[c*OP_W +: OP_W] == OP_RECV;
      elig        = reqValid[c] && !ackQ[c];
      good[c]     = elig && (isSend[c] || isRecv[c]) && inRange && wired && peerOk;
      bad[c]      = elig && !((isSend[c] || isRecv[c]) && inRange && wired && peerOk);
    end
  end

  // Pair matching: both ends present, facing each other, opposite directions.
  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      logic [CORE_W-1:0] p;
      p = peerCore[c];
      matchNext[c] = good[c] && good[p] && (ownSlot[p] == peerSlot[c])
                     && (isSend[c] != isSend[p]);
      loadRx[c]    = matchNext[c] && isRecv[c];
      srcCore[c*CORE_W +: CORE_W]           = p;
      slotLow[c*LINK_SLOT_W +: LINK_SLOT_W] = ownSlot[c];
    end
  end

  always_comb begin
    errCoreNext = '0;
    for (int c = NUM_CORES-1; c >= 0; c--) begin
      if (bad[c]) errCoreNext = CORE_W'(c);
    end
    strobe.errHit  = |bad;
    strobe.deadHit = (&good) && !(|matchNext);
  end
endmodule

// File: rtl/link_datapath.sv
module link_datapath
  import link_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int PC_W      = 16,
  parameter int CORE_W    = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_CORES*DATA_W-1:0]      reqData,
  input  logic [NUM_CORES*PC_W-1:0]        reqPc,
  input  logic [NUM_CORES-1:0]             matchNext,
  input  logic [NUM_CORES-1:0]             loadRx,
  input  logic [NUM_CORES*CORE_W-1:0]      srcCore,
  input  logic [NUM_CORES*LINK_SLOT_W-1:0] slotLow,
  input  logic [CORE_W-1:0]                errCoreNext,
  input  link_strobe_t                     strobe,
  output logic [NUM_CORES-1:0]             ackQ,
  output logic [NUM_CORES*DATA_W-1:0]      rxData,
  output logic                             errValid,
  output logic [CORE_W-1:0]                errCore,
  output logic [PC_W-1:0]                  errPc,
  output logic                             deadlock,
  output logic [NUM_CORES*LINK_SLOT_W-1:0] waitSlot
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ     <= '0;
      rxData   <= '0;
      errValid <= 1'b0;
      errCore  <= '0;
      errPc    <= '0;
      deadlock <= 1'b0;
      waitSlot <= '0;
    end else begin
      ackQ     <= matchNext;
      errValid <= strobe.errHit;
      deadlock <= strobe.deadHit;
      waitSlot <= strobe.deadHit ? slotLow : '0;
      if (strobe.errHit) begin
        errCore <= errCoreNext;
        errPc   <= reqPc[int'(errCoreNext)*PC_W +: PC_W];
      end
      for (int c = 0; c < NUM_CORES; c++) begin
        if (loadRx[c])
          rxData[c*DATA_W +: DATA_W] <=
            reqData[int'(srcCore[c*CORE_W +: CORE_W])*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/link_rendezvous.sv
module link_rendezvous
  import link_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SLOT_IN_W = 8,
  parameter int DATA_W    = 32,
  parameter int PC_W      = 16,
  parameter logic [NUM_CORES*LINK_SLOTS*ENTRY_W-1:0] PEER_MAP = link_default_map(),
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_CORES-1:0]             reqValid,
  input  logic [NUM_CORES*OP_W-1:0]        reqOp,
  input  logic [NUM_CORES*SLOT_IN_W-1:0]   reqSlot,
  input  logic [NUM_CORES*DATA_W-1:0]      reqData,
  input  logic [NUM_CORES*PC_W-1:0]        reqPc,
  output logic [NUM_CORES-1:0]             ackOut,
  output logic [NUM_CORES*DATA_W-1:0]      rxData,
  output logic                             errValid,
  output logic [CORE_W-1:0]                errCore,
  output logic [PC_W-1:0]                  errPc,
  output logic                             deadlock,
  output logic [NUM_CORES*LINK_SLOT_W-1:0] waitSlot
);
  logic [NUM_CORES-1:0]             matchNext, loadRx, ackQ;
  logic [NUM_CORES*CORE_W-1:0]      srcCore;
  logic [NUM_CORES*LINK_SLOT_W-1:0] slotLow;
  logic [CORE_W-1:0]                errCoreNext;
  link_strobe_t                     strobe;

  link_ctrl #(
    .NUM_CORES(NUM_CORES), .SLOT_IN_W(SLOT_IN_W), .CORE_W(CORE_W), .PEER_MAP(PEER_MAP)
  ) u_ctrl (
    .reqValid(reqValid), .reqOp(reqOp), .reqSlot(reqSlot), .ackQ(ackQ),
    .matchNext(matchNext), .loadRx(loadRx), .srcCore(srcCore), .slotLow(slotLow),
    .errCoreNext(errCoreNext), .strobe(strobe)
  );

  link_datapath #(
    .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .PC_W(PC_W), .CORE_W(CORE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqData(reqData), .reqPc(reqPc),
    .matchNext(matchNext), .loadRx(loadRx), .srcCore(srcCore), .slotLow(slotLow),
    .errCoreNext(errCoreNext), .strobe(strobe),
    .ackQ(ackQ), .rxData(rxData), .errValid(errValid), .errCore(errCore),
    .errPc(errPc), .deadlock(deadlock), .waitSlot(waitSlot)
  );

  assign ackOut = ackQ;
endmodule

// File: rtl/link_rendezvous_chk.sv
module link_rendezvous_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 2
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_CORES-1:0]        reqValid,
  input logic [NUM_CORES-1:0]        ackOut,
  input logic [NUM_CORES*DATA_W-1:0] rxData,
  input logic                        errValid,
  input logic [CORE_W-1:0]           errCore,
  input logic                        deadlock
);
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut & ~$past(reqValid)) == '0);  // R3
  AST_ACK_IN_PAIRS: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(ackOut) % 2) == 0);  // R5
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (|ackOut) |=> ((ackOut & $past(ackOut)) == '0));  // R6
  AST_NO_ACK_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> !ackOut[errCore]);  // R8
  AST_DEAD_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    deadlock |-> (ackOut == '0));  // R9
  AST_DEAD_ALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    deadlock |-> (&$past(reqValid)));  // R10

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_rx
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !ackOut[c] |-> $stable(rxData[c*DATA_W +: DATA_W]));  // R5
  end
endmodule

bind link_rendezvous link_rendezvous_chk #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .CORE_W(CORE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .ackOut(ackOut), .rxData(rxData),
  .errValid(errValid), .errCore(errCore), .deadlock(deadlock)
);

// File: tb/link_rendezvous_bench.sv
module link_rendezvous_bench;
  localparam int NC = 4, SW = 8, DW = 32, PW = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NC-1:0]   reqValid = '0;
  logic [NC*4-1:0] reqOp = '0;
  logic [NC*SW-1:0] reqSlot = '0;
  logic [NC*DW-1:0] reqData = '0;
  logic [NC*PW-1:0] reqPc = '0;
  logic [NC-1:0]   ackOut;
  logic [NC*DW-1:0] rxData;
  logic            errValid;
  logic [1:0]      errCore;
  logic [PW-1:0]   errPc;
  logic            deadlock;
  logic [NC*2-1:0] waitSlot;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  link_rendezvous u_link_rendezvous (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqSlot(reqSlot),
    .reqData(reqData), .reqPc(reqPc), .ackOut(ackOut), .rxData(rxData),
    .errValid(errValid), .errCore(errCore), .errPc(errPc), .deadlock(deadlock),
    .waitSlot(waitSlot)
  );

  // Wired pairs as the bench understands them: {coreA, slotA, coreB, slotB}.
  function automatic logic [7:0] pairOf(input int k);
    case (k)
      0:       return {2'd0, 2'd0, 2'd1, 2'd0};
      1:       return {2'd2, 2'd1, 2'd3, 2'd2};
      2:       return {2'd0, 2'd2, 2'd2, 2'd3};
      default: return {2'd1, 2'd3, 2'd3, 2'd0};
    endcase
  endfunction

  function automatic logic [NC-1:0] ackMask(input int a, input int b);
    return (NC'(1) << a) | (NC'(1) << b);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setReq(input int c, input logic [3:0] op, input logic [7:0] slot,
                        input logic [31:0] data, input logic [15:0] pc);
    reqOp[c*4 +: 4]    = op;
    reqSlot[c*SW +: SW] = slot;
    reqData[c*DW +: DW] = data;
    reqPc[c*PW +: PW]   = pc;
    reqValid[c]         = 1'b1;
  endtask

  task automatic clrAll();
    reqValid = '0;
  endtask

  // One rendezvous; firstSend chooses which side arrives first.
  task automatic transfer(input int sc, input int ss, input int rc, input int rs,
                          input bit firstSend, input int gap, input logic [31:0] data);
    string waitTag;
    waitTag = firstSend ? "R3" : "R4";
    if (firstSend) setReq(sc, 4'h5, 8'(ss), data, 16'(sc));
    else           setReq(rc, 4'h4, 8'(rs), 32'h0, 16'(rc));
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk(ackOut == '0, waitTag, 32'(ackOut), 32'h0);
    end
    if (firstSend) setReq(rc, 4'h4, 8'(rs), 32'h0, 16'(rc));
    else           setReq(sc, 4'h5, 8'(ss), data, 16'(sc));
    @(negedge clk);
    chk(ackOut == ackMask(sc, rc), "R5 ack", 32'(ackOut), 32'(ackMask(sc, rc)));
    chk(rxData[rc*DW +: DW] == data, "R2 R5 data", rxData[rc*DW +: DW], data);
    chk(errValid == 1'b0, "R8 quiet", 32'(errValid), 32'h0);
    @(negedge clk);  // requests still present through the ack cycle
    chk(ackOut == '0, "R6", 32'(ackOut), 32'h0);
    clrAll();
    @(negedge clk);
    chk(rxData[rc*DW +: DW] == data, "R5 hold", rxData[rc*DW +: DW], data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ackOut == '0 && errValid == 1'b0 && deadlock == 1'b0 && waitSlot == '0
        && rxData == '0, "R1", 32'(ackOut), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed orderings.
    transfer(0, 0, 1, 0, 1'b1, 3, 32'hCAFE_0001);  // sender early
    transfer(3, 2, 2, 1, 1'b0, 4, 32'h0BAD_F00D);  // receiver early
    transfer(2, 3, 0, 2, 1'b1, 0, 32'h1234_5678);  // simultaneous

    // Random traffic.
    for (int n = 0; n < 40; n++) begin
      logic [7:0] p;
      bit         aSends;
      p = pairOf(int'($urandom % 4));
      aSends = 1'($urandom);
      if (aSends)
        transfer(int'(p[7:6]), int'(p[5:4]), int'(p[3:2]), int'(p[1:0]),
                 1'($urandom), int'($urandom % 5), $urandom);
      else
        transfer(int'(p[3:2]), int'(p[1:0]), int'(p[7:6]), int'(p[5:4]),
                 1'($urandom), int'($urandom % 5), $urandom);
    end

    // R7: both ends send, then both ends receive.
    setReq(0, 4'h5, 8'd0, 32'h1, 16'h0);
    setReq(1, 4'h5, 8'd0, 32'h2, 16'h0);
    repeat (3) @(negedge clk);
    chk(ackOut == '0, "R7 send-send", 32'(ackOut), 32'h0);
    clrAll();
    setReq(2, 4'h4, 8'd1, 32'h0, 16'h0);
    setReq(3, 4'h4, 8'd2, 32'h0, 16'h0);
    repeat (3) @(negedge clk);
    chk(ackOut == '0, "R7 recv-recv", 32'(ackOut), 32'h0);
    chk(deadlock == 1'b0, "R10 idle cores", 32'(deadlock), 32'h0);
    clrAll();
    @(negedge clk);

    // R8: unwired slot.
    setReq(2, 4'h5, 8'd0, 32'h9, 16'h1234);
    @(negedge clk);
    chk(errValid == 1'b1, "R8 flag", 32'(errValid), 32'h1);
    chk(errCore == 2'd2, "R8 core", 32'(errCore), 32'h2);
    chk(errPc == 16'h1234, "R8 pc", 32'(errPc), 32'h1234);
    chk(ackOut[2] == 1'b0, "R8 no ack", 32'(ackOut), 32'h0);
    clrAll();
    @(negedge clk);
    chk(errValid == 1'b0, "R8 clear", 32'(errValid), 32'h0);

    // R8: bad op on core 1 and out-of-range slot on core 3 together.
    setReq(1, 4'h7, 8'd0, 32'h0, 16'h00A1);
    setReq(3, 4'h4, 8'd9, 32'h0, 16'h00B3);
    @(negedge clk);
    chk(errValid == 1'b1 && errCore == 2'd1, "R8 lowest", 32'(errCore), 32'h1);
    chk(errPc == 16'h00A1, "R8 pc lowest", 32'(errPc), 32'hA1);
    clrAll();
    @(negedge clk);

    // R9: all four cores stuck on same-direction pairs.
    setReq(0, 4'h5, 8'd0, 32'h0, 16'h0);
    setReq(1, 4'h5, 8'd0, 32'h0, 16'h0);
    setReq(2, 4'h4, 8'd1, 32'h0, 16'h0);
    setReq(3, 4'h4, 8'd2, 32'h0, 16'h0);
    @(negedge clk);
    chk(deadlock == 1'b1, "R9 flag", 32'(deadlock), 32'h1);
    chk(waitSlot == 8'h90, "R9 slots", 32'(waitSlot), 32'h90);
    chk(ackOut == '0, "R9 no ack", 32'(ackOut), 32'h0);
    clrAll();
    @(negedge clk);
    chk(deadlock == 1'b0 && waitSlot == '0, "R9 clear", 32'(deadlock), 32'h0);

    // R10: three stuck plus one erroneous core is not deadlock.
    setReq(0, 4'h5, 8'd0, 32'h0, 16'h0);
    setReq(1, 4'h5, 8'd0, 32'h0, 16'h0);
    setReq(2, 4'h4, 8'd1, 32'h0, 16'h0);
    setReq(3, 4'h4, 8'd7, 32'h0, 16'h0077);
    repeat (2) @(negedge clk);
    chk(deadlock == 1'b0, "R10 error core", 32'(deadlock), 32'h0);
    chk(errValid == 1'b1 && errCore == 2'd3, "R8 core3", 32'(errCore), 32'h3);
    clrAll();
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule